// File: doc/BRIEF.md
# Accumulating Row Bank with Quantising Read-Out

This block is a row-organised storage bank for partial sums. Each row holds DIM signed 32-bit elements. A write either replaces a row or adds its data, element by element, onto the row already stored. Write data comes in one of two forms: full 32-bit elements, or 8-bit elements that are sign-extended before use. Accumulation is a read-modify-write over two internal stages. When accumulates to the same row arrive on consecutive cycles, a forwarding path makes sure none of the additions is lost.

Reads come in two forms, and each has its own output port. A raw read returns the stored 32-bit row two cycles after the request. A quantising read returns one byte per element three cycles after the request. Each byte is the element after three steps: an arithmetic right shift by a power of two with round-half-up, an optional rectifier (plain, or capped at a programmable ceiling), and saturation to the signed 8-bit range. A typical use collects the partial-sum outputs of a matrix engine with accumulate writes. The finished sums are then read back as quantised 8-bit activations for the next layer.

Top module: `acc_scale_bank`

## Requirements
- R1: An overwrite write (wr_accum=0, wr_narrow=0) stores wr_row unchanged, element i taken from bits [32i+31:32i].
- R2: With wr_narrow=1, element i is the byte at bits [8i+7:8i] of wr_row, sign-extended to 32 bits. Bits above DIM*8 are ignored.
- R3: An accumulate write (wr_accum=1) stores the stored element plus the incoming element, modulo 2^32, for every element. Narrow data is widened first.
- R4: Accumulates to the same row requested on consecutive cycles, or with one cycle between them, all take effect. The final row equals the sum of every contribution.
- R5: A read requested three or more cycles after a write request returns the row as that write left it.
- R6: A raw read (rd_quant=0) raises raw_valid for one cycle exactly two cycles after the request, with raw_row holding the stored row in the R1 layout.
- R7: A quantising read (rd_quant=1) raises q_valid for one cycle exactly three cycles after the request. Before activation, each element becomes (x + 2^(s-1)) >> s, an arithmetic shift, with s = rd_shift. When s=0 the element is left unchanged.
- R8: After activation, each quantised element saturates to [-128, 127]. Element i is placed at q_row bits [8i+7:8i].
- R9: rd_act selects the activation. 0 applies none. 1 sets negative values to 0. 2 sets negative values to 0 and caps them at relu6_max, which is read as unsigned and sampled with the request. 3 behaves as 0.
- R10: After reset, raw_valid and q_valid are low.
- R11: Raw and quantising reads may be issued back-to-back in any order. Each result appears on its own port at its own latency, so both ports may be valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write request |
| wr_addr | input | AW | Row written |
| wr_accum | input | 1 | 1 = add onto stored row, 0 = overwrite |
| wr_narrow | input | 1 | 1 = 8-bit elements in the low DIM*8 bits |
| wr_row | input | DIM*32 | Write data |
| rd_valid | input | 1 | Read request |
| rd_addr | input | AW | Row read |
| rd_quant | input | 1 | 1 = quantising read, 0 = raw read |
| rd_shift | input | 5 | Right-shift amount for quantising reads |
| rd_act | input | 2 | Activation select |
| relu6_max | input | 8 | Ceiling for the capped rectifier |
| raw_valid | output | 1 | Raw result valid |
| raw_row | output | DIM*32 | Raw result row |
| q_valid | output | 1 | Quantised result valid |
| q_row | output | DIM*8 | Quantised result row |

## Verification
The hardest case to reach is the forwarding path. It only matters when a second accumulate to the same row enters the read stage while the first is still waiting to be written back, and ports alone cannot show whether the forwarded value was used. The stimulus therefore sends runs of accumulates to one row on consecutive cycles, and interleaves another row so that same-row requests also arrive two cycles apart. It then checks that the final row holds the full sum. Rounding at the half point for negative values, and the interaction of the cap with saturation, come from sweeping every shift and activation code over rows chosen to sit on those boundaries.

// File: rtl/acc_scale_bank_pkg.sv
package acc_scale_bank_pkg;
  localparam int ACC_W = 32;
  localparam int NAR_W = 8;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_RELU  = 2'd1,
    ACT_RELU6 = 2'd2,
    ACT_RSVD  = 2'd3
  } act_e;

  // sign-extend an 8-bit element to the accumulator width
  function automatic logic [ACC_W-1:0] widen8(input logic [NAR_W-1:0] b);
    return {{(ACC_W-NAR_W){b[NAR_W-1]}}, b};
  endfunction

  // arithmetic right shift with round-half-up, kept one bit wider
  function automatic logic signed [ACC_W:0] shift_round(input logic [ACC_W-1:0] x,
                                                       input logic [4:0] s);
    logic signed [ACC_W:0] ext;
    logic signed [ACC_W:0] bias;
    ext  = $signed({x[ACC_W-1], x});
    bias = '0;
    if (s != 5'd0) bias[s - 5'd1] = 1'b1;
    return (ext + bias) >>> s;
  endfunction

  // activation followed by saturation to signed 8 bits
  function automatic logic [NAR_W-1:0] act_sat(input logic signed [ACC_W:0] y,
                                               input act_e a,
                                               input logic [NAR_W-1:0] ceil_v);
    logic signed [ACC_W:0] t;
    logic signed [ACC_W:0] c;
    t = y;
    c = $signed({{(ACC_W+1-NAR_W){1'b0}}, ceil_v});
    if ((a == ACT_RELU || a == ACT_RELU6) && t < 0) t = '0;
    if (a == ACT_RELU6 && t > c) t = c;
    if (t > 33'sd127) return 8'h7f;
    if (t < -33'sd128) return 8'h80;
    return t[NAR_W-1:0];
  endfunction
endpackage

// File: rtl/acc_row_mem.sv
module acc_row_mem #(
  parameter int DIM = 4,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic [AW-1:0]     fetch_addr,
  output logic [DIM*32-1:0] fetch_row,
  input  logic [AW-1:0]     look_addr,
  output logic [DIM*32-1:0] look_row,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DIM*32-1:0] wrow
);
  localparam int DEPTH = 1 << AW;
  logic [DIM*32-1:0] rows [DEPTH];

  assign fetch_row = rows[fetch_addr];
  assign look_row  = rows[look_addr];

  always_ff @(posedge clk) begin
    if (we) rows[waddr] <= wrow;
  end
endmodule

// File: rtl/acc_write_pipe.sv
module acc_write_pipe
  import acc_scale_bank_pkg::*;
#(
  parameter int DIM = 4,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_accum,
  input  logic              wr_narrow,
  input  logic [DIM*32-1:0] wr_row,
  output logic [AW-1:0]     fetch_addr,
  input  logic [DIM*32-1:0] fetch_row,
  output logic              wb_fire,
  output logic [AW-1:0]     wb_addr,
  output logic [DIM*32-1:0] wb_row,
  output logic              byp_hit
);
  localparam int RW = DIM * ACC_W;

  logic [RW-1:0] wide_in;
  logic          v1, acc1, v2, acc2;
  logic [AW-1:0] a1, a2;
  logic [RW-1:0] d1, d2, old2;

  for (genvar i = 0; i < DIM; i++) begin : g_lane
    assign wide_in[i*ACC_W +: ACC_W] = wr_narrow ? widen8(wr_row[i*NAR_W +: NAR_W])
                                                 : wr_row[i*ACC_W +: ACC_W];
    assign wb_row[i*ACC_W +: ACC_W] = acc2 ? old2[i*ACC_W +: ACC_W] + d2[i*ACC_W +: ACC_W]
                                           : d2[i*ACC_W +: ACC_W];
  end

  assign fetch_addr = a1;
  assign byp_hit    = v1 && v2 && (a1 == a2);
  assign wb_fire    = v2;
  assign wb_addr    = a2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= wr_valid;
      v2 <= v1;
    end
  end

  always_ff @(posedge clk) begin
    a1   <= wr_addr;
    acc1 <= wr_accum;
    d1   <= wide_in;
    a2   <= a1;
    acc2 <= acc1;
    d2   <= d1;
    old2 <= byp_hit ? wb_row : fetch_row;
  end
endmodule

// File: rtl/acc_quant_lane.sv
module acc_quant_lane
  import acc_scale_bank_pkg::*;
(
  input  logic             clk,
  input  logic [ACC_W-1:0] x,
  input  logic [4:0]       sh,
  input  logic [1:0]       act,
  input  logic [NAR_W-1:0] ceil_v,
  output logic [NAR_W-1:0] y
);
  logic signed [ACC_W:0] mid;

  always_ff @(posedge clk) begin
    mid <= shift_round(x, sh);
    y   <= act_sat(mid, act_e'(act), ceil_v);
  end
endmodule

// File: rtl/acc_scale_bank.sv
module acc_scale_bank
  import acc_scale_bank_pkg::*;
#(
  parameter int DIM = 4,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_accum,
  input  logic              wr_narrow,
  input  logic [DIM*32-1:0] wr_row,
  input  logic              rd_valid,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_quant,
  input  logic [4:0]        rd_shift,
  input  logic [1:0]        rd_act,
  input  logic [7:0]        relu6_max,
  output logic              raw_valid,
  output logic [DIM*32-1:0] raw_row,
  output logic              q_valid,
  output logic [DIM*8-1:0]  q_row
);
  localparam int RW = DIM * ACC_W;

  logic [AW-1:0] fetch_addr, wb_addr;
  logic [RW-1:0] fetch_row, look_row, wb_row;
  logic          wb_fire, byp_hit;

  logic          r1_v, r1_q, q2_v;
  logic [RW-1:0] r1_row;
  logic [4:0]    r1_sh;
  logic [1:0]    r1_act, act2;
  logic [7:0]    r1_ceil, ceil2;

  acc_row_mem #(.DIM(DIM), .AW(AW)) u_mem (
    .clk(clk), .fetch_addr(fetch_addr), .fetch_row(fetch_row),
    .look_addr(rd_addr), .look_row(look_row),
    .we(wb_fire), .waddr(wb_addr), .wrow(wb_row)
  );

  acc_write_pipe #(.DIM(DIM), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_accum(wr_accum), .wr_narrow(wr_narrow), .wr_row(wr_row),
    .fetch_addr(fetch_addr), .fetch_row(fetch_row),
    .wb_fire(wb_fire), .wb_addr(wb_addr), .wb_row(wb_row), .byp_hit(byp_hit)
  );

  for (genvar i = 0; i < DIM; i++) begin : g_q
    acc_quant_lane u_lane (
      .clk(clk), .x(r1_row[i*ACC_W +: ACC_W]), .sh(r1_sh),
      .act(act2), .ceil_v(ceil2), .y(q_row[i*NAR_W +: NAR_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_v      <= 1'b0;
      q2_v      <= 1'b0;
      raw_valid <= 1'b0;
      q_valid   <= 1'b0;
    end else begin
      r1_v      <= rd_valid;
      raw_valid <= r1_v && !r1_q;
      q2_v      <= r1_v && r1_q;
      q_valid   <= q2_v;
    end
  end

  always_ff @(posedge clk) begin
    r1_row  <= look_row;
    r1_q    <= rd_quant;
    r1_sh   <= rd_shift;
    r1_act  <= rd_act;
    r1_ceil <= relu6_max;
    raw_row <= r1_row;
    act2    <= r1_act;
    ceil2   <= r1_ceil;
  end
endmodule

// File: rtl/acc_scale_bank_chk.sv
module acc_scale_bank_chk #(
  parameter int DIM = 4,
  parameter int AW  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic [AW-1:0]    wr_addr,
  input logic             rd_valid,
  input logic             rd_quant,
  input logic [1:0]       rd_act,
  input logic             raw_valid,
  input logic             q_valid,
  input logic [DIM*8-1:0] q_row,
  input logic             wb_fire,
  input logic             byp_hit
);
  function automatic logic all_nonneg(input logic [DIM*8-1:0] r);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIM; i++) if (r[i*8+7]) ok = 1'b0;
    return ok;
  endfunction

  assert_raw_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid |-> $past(rd_valid, 2) && !$past(rd_quant, 2));

  assert_quant_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> $past(rd_valid, 3) && $past(rd_quant, 3));

  assert_relu_nonneg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && $past(rd_act, 3) == 2'd1) |-> all_nonneg(q_row));

  assert_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> $past(wr_valid, 2));

  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byp_hit |-> $past(wr_valid, 1) && $past(wr_valid, 2) &&
                $past(wr_addr, 1) == $past(wr_addr, 2));
endmodule

bind acc_scale_bank acc_scale_bank_chk #(.DIM(DIM), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .rd_valid(rd_valid), .rd_quant(rd_quant), .rd_act(rd_act),
  .raw_valid(raw_valid), .q_valid(q_valid), .q_row(q_row),
  .wb_fire(wb_fire), .byp_hit(byp_hit)
);

// File: tb/acc_scale_bank_tb.sv
`timescale 1ns/1ps
module acc_scale_bank_tb;
  localparam int DIM = 4;
  localparam int AW  = 4;
  localparam int RW  = DIM * 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_accum = 0, wr_narrow = 0, rd_valid = 0, rd_quant = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [RW-1:0] wr_row = '0;
  logic [4:0] rd_shift = '0;
  logic [1:0] rd_act = '0;
  logic [7:0] relu6_max = '0;
  logic raw_valid, q_valid;
  logic [RW-1:0] raw_row;
  logic [DIM*8-1:0] q_row;

  acc_scale_bank #(.DIM(DIM), .AW(AW)) u_dut (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  typedef struct { int due; logic [RW-1:0] row; string tag; } item_t;
  item_t raw_sb[$];
  item_t q_sb[$];
  logic [RW-1:0] mdl [1 << AW];

  task automatic check(input bit ok, input string tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_q(input logic [31:0] x, input int s, input int a, input int cap);
    longint r;
    r = longint'($signed(x));
    if (s > 0) r = (r + (longint'(1) << (s - 1))) >>> s;
    if ((a == 1 || a == 2) && r < 0) r = 0;
    if (a == 2 && r > cap) r = cap;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r[7:0];
  endfunction

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_valid = 0; rd_valid = 0;
    end
  endtask

  task automatic wr(input int a, input bit acc, input bit nar, input logic [RW-1:0] d);
    logic [RW-1:0] nv;
    @(negedge clk);
    rd_valid = 0; wr_valid = 1; wr_addr = a[AW-1:0];
    wr_accum = acc; wr_narrow = nar; wr_row = d;
    for (int i = 0; i < DIM; i++) begin
      logic [31:0] e;
      e = nar ? {{24{d[i*8+7]}}, d[i*8 +: 8]} : d[i*32 +: 32];
      nv[i*32 +: 32] = acc ? mdl[a][i*32 +: 32] + e : e;
    end
    mdl[a] = nv;
  endtask

  task automatic rd(input int a, input bit q, input int s, input int act, input int cap, input string tag);
    item_t it;
    @(negedge clk);
    wr_valid = 0; rd_valid = 1; rd_addr = a[AW-1:0]; rd_quant = q;
    rd_shift = s[4:0]; rd_act = act[1:0]; relu6_max = cap[7:0];
    it.tag = tag;
    it.row = '0;
    if (!q) begin
      it.due = cyc + 2; it.row = mdl[a]; raw_sb.push_back(it);
    end else begin
      it.due = cyc + 3;
      for (int i = 0; i < DIM; i++) it.row[i*8 +: 8] = exp_q(mdl[a][i*32 +: 32], s, act, cap);
      q_sb.push_back(it);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (raw_valid) begin
        if (raw_sb.size() == 0) check(0, "R6 unexpected raw_valid", raw_row, '0);
        else begin
          item_t it;
          it = raw_sb.pop_front();
          check(it.due == cyc, {it.tag, " R6 timing"}, RW'(cyc), RW'(it.due));
          check(raw_row == it.row, it.tag, raw_row, it.row);
        end
      end else if (raw_sb.size() != 0 && raw_sb[0].due <= cyc) begin
        check(0, {raw_sb[0].tag, " R6 missing raw_valid"}, '0, 1);
        void'(raw_sb.pop_front());
      end
      if (q_valid) begin
        if (q_sb.size() == 0) check(0, "R7 unexpected q_valid", RW'(q_row), '0);
        else begin
          item_t it;
          it = q_sb.pop_front();
          check(it.due == cyc, {it.tag, " R7 timing"}, RW'(cyc), RW'(it.due));
          check(RW'(q_row) == it.row, it.tag, RW'(q_row), it.row);
        end
      end else if (q_sb.size() != 0 && q_sb[0].due <= cyc) begin
        check(0, {q_sb[0].tag, " R7 missing q_valid"}, '0, 1);
        void'(q_sb.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", '0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(raw_valid == 0 && q_valid == 0, "R10 reset valids", RW'({raw_valid, q_valid}), '0);

    // R1 overwrite, R6 raw read
    wr(1, 0, 0, {32'd7, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678});
    idle(2);
    rd(1, 0, 0, 0, 0, "R1 overwrite row");
    // R2 narrow write with junk above the byte field
    wr(2, 0, 1, {96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h05FF_7F80});
    idle(2);
    rd(2, 0, 0, 0, 0, "R2 narrow sign-extend");
    // R3 accumulate incl. wrap, wide and narrow
    wr(1, 1, 0, {32'hFFFF_FFF9, 32'h8000_0000, 32'd1, 32'd1});
    idle(2);
    rd(1, 0, 0, 0, 0, "R3 accumulate wrap");
    wr(2, 1, 1, {96'h0, 32'h80_01_FF_80});
    idle(2);
    rd(2, 0, 0, 0, 0, "R3 narrow accumulate");
    // R4 back-to-back and one-apart accumulates
    wr(3, 0, 0, {32'd40, 32'd30, 32'd20, 32'd10});
    wr(4, 0, 0, {32'd4, 32'd3, 32'd2, 32'd1});
    wr(3, 1, 0, {32'd4, 32'd3, 32'd2, 32'd1});
    wr(3, 1, 0, {32'd4, 32'd3, 32'd2, 32'd1});
    wr(3, 1, 1, {96'h0, 32'hFF_FF_FF_FF});
    wr(4, 1, 0, {32'd100, 32'd100, 32'd100, 32'd100});
    wr(3, 1, 0, {32'd1000, 32'd1000, 32'd1000, 32'd1000});
    wr(4, 1, 0, {32'd7, 32'd7, 32'd7, 32'd7});
    wr(3, 1, 0, {32'd5, 32'd5, 32'd5, 32'd5});
    idle(2);
    rd(3, 0, 0, 0, 0, "R4 chained accumulate row3");
    rd(4, 0, 0, 0, 0, "R4 chained accumulate row4");
    // R5 read exactly three cycles after the write request
    wr(5, 0, 0, {32'd11, 32'd22, 32'd33, 32'd44});
    idle(2);
    rd(5, 0, 0, 0, 0, "R5 write visible");
    wr(5, 1, 0, {32'd1, 32'd1, 32'd1, 32'd1});
    idle(2);
    rd(5, 0, 0, 0, 0, "R5 accumulate visible");

    // R7 R8 R9 quantising sweep
    wr(6, 0, 0, {32'hFFFF_FFFA, 32'd6, 32'hFFFF_FFFB, 32'd5});
    wr(7, 0, 0, {32'd255, 32'hFFFF_FC18, 32'd1000, 32'h7FFF_FFFF});
    wr(8, 0, 0, {32'd12, 32'hFFFF_FF7F, 32'd128, 32'h8000_0000});
    idle(2);
    for (int a = 6; a <= 8; a++)
      for (int s = 0; s < 6; s++)
        for (int act = 0; act < 4; act++)
          rd(a, 1, s, act, (s % 2) ? 6 : 200, "R7 R8 R9 quant sweep");
    rd(7, 1, 31, 0, 0, "R7 max shift");
    rd(8, 1, 31, 0, 0, "R7 max shift negative");

    // R11 interleaved raw and quantising reads
    for (int k = 0; k < 8; k++) begin
      rd(6 + k % 3, k % 2, k, 2, 3, "R11 interleaved raw/quant");
    end

    // mixed random traffic
    for (int k = 0; k < 40; k++) begin
      int a;
      a = 9 + int'($urandom_range(0, 6));
      wr(a, (k > 6) ? bit'($urandom_range(0, 1)) : 1'b0, bit'($urandom_range(0, 1)),
         {$urandom, $urandom, $urandom, $urandom});
      idle(2);
      rd(a, 0, 0, 0, 0, "R3 random raw");
      rd(a, 1, int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
         int'($urandom_range(0, 255)), "R8 random quant");
    end

    idle(8);
    check(raw_sb.size() == 0 && q_sb.size() == 0, "R6 R7 all responses seen",
          RW'(raw_sb.size() + q_sb.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule